// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Unit

This block is the software-visible register file of a multi-channel DMA engine. Channels come in receive/transmit pairs: an instance of the register file serves one pair, and the instances sit at a fixed stride in the address space. Each channel holds a descriptor pointer, split into high and low words, plus two extra parameter words. The receive side adds an enable bit and a bytes-per-row word. A single addressing-control register and three interrupt registers (status, pending, mask) are shared by all channels.

The channel engines report the end of a descriptor chain with a one-cycle pulse per channel. That pulse sets a sticky status bit. Software clears status bits by writing ones. The pending view is the status masked by the enable register, and one interrupt line is raised while any pending bit is set. Starting a channel is signalled to its engine by a one-cycle strobe. A transmit channel starts when its descriptor-low word is written. A receive channel starts when its enable bit goes from 0 to 1.

The bus is a simple word-addressed register port carrying byte addresses. A write takes effect on the clock edge where `bus_wr` is sampled. Read data is registered and appears on `bus_rdata` after the edge where `bus_rd` is sampled, then holds until the next read.

Top module: `dma_regfile`

## Requirements
- R1: Instance n serves channel 2n (receive) at byte base n*0x40 and channel 2n+1 (transmit) at n*0x40+0x18. Channel c's descriptor words drive `chan_desc_hi`/`chan_desc_lo` slice [c*32 +: 32]. Instance n's receive enable and row word drive `rx_enable[n]` and `rx_row_bytes[n*32 +: 32]`.
- R2: Receive registers, as offsets from the instance base: descriptor high 0x00, descriptor low 0x04, parameter words 0x0C and 0x10, enable 0x14, bytes-per-row 0x30. All are full 32-bit read/write except enable, which keeps only bit 0 and reads zero in bits 31:1.
- R3: Transmit registers, as offsets from the transmit base: descriptor high 0x00, descriptor low 0x04, parameter words 0x0C and 0x14. All are 32-bit read/write.
- R4: The addressing-control register at absolute byte address 0x34 keeps bit 0, reads it back in bit 0, and drives `addr32_mode`. The same offset in any instance other than instance 0 is unmapped.
- R5: A pulse on `chain_done[i]` sets bit i of the status register at 0x080000. Status bits are sticky.
- R6: Writing the status register clears every bit written as 1 and leaves bits written as 0 unchanged, so writing 0xFFFFFFFF clears all of them.
- R7: When a done pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R8: The mask register at 0x080008 is read/write (one bit per channel). The pending register at 0x080004 reads status AND mask, and writes to it have no effect.
- R9: `irq` is high exactly when status AND mask is nonzero. It follows a register change in the same cycle that the change becomes visible.
- R10: Writing a transmit descriptor-low register raises `chan_start` for that channel for exactly one cycle after the write edge.
- R11: Writing 1 to a receive enable that holds 0 raises `chan_start` for that channel for one cycle. Writing 1 when it already holds 1 gives no strobe.
- R12: Reads of unmapped or non-word-aligned addresses return zero, and writes to them change no register.
- R13: After reset every register, `bus_rdata`, `irq`, `addr32_mode` and every `chan_start` bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write request |
| bus_rd | input | 1 | Register read request |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| chain_done | input | NCH | Per-channel end-of-chain pulses |
| irq | output | 1 | Interrupt, high while any pending bit is set |
| addr32_mode | output | 1 | Addressing-control bit 0 |
| chan_desc_hi | output | NCH*32 | Descriptor address high word per channel |
| chan_desc_lo | output | NCH*32 | Descriptor address low word per channel |
| rx_enable | output | NUM_INST | Receive enable per instance |
| rx_row_bytes | output | NUM_INST*32 | Bytes-per-row per instance |
| chan_start | output | NCH | One-cycle start strobes per channel |

## Verification
Every register output, start strobe and `irq` reflects a write or a done pulse on the first clock edge that samples it. The bench drives stimulus on a falling edge and checks these at the next falling edge. Read data is also registered once, so every read is issued on a falling edge and compared one full cycle later. The strobe tests check the cycle after the strobe as well, which confirms that it lasts one cycle. The same-cycle collision between a done pulse and a clear is driven within a single sampled edge.

// File: rtl/dma_rf_pkg.sv
// Shared decode types and address constants of the DMA register unit.
// Assumes byte addressing, 32-bit registers, 64-byte instance stride.
package dma_rf_pkg;

    typedef enum logic [3:0] {
        RK_NONE, RK_RX_DHI, RK_RX_DLO, RK_RX_XA, RK_RX_XB, RK_RX_EN,
        RK_RX_ROW, RK_TX_DHI, RK_TX_DLO, RK_TX_XA, RK_TX_XB,
        RK_ADDR_CTL, RK_STATUS, RK_PEND, RK_MASK
    } reg_kind_e;

    localparam int INST_SPAN   = 64;
    localparam int TX_BASE     = 24;
    localparam int STATUS_ADDR = 32'h0008_0000;
    localparam int PEND_ADDR   = 32'h0008_0004;
    localparam int MASK_ADDR   = 32'h0008_0008;

    // Map an in-instance byte offset to a register kind.
    function automatic reg_kind_e inst_kind(input logic [5:0] off, input logic first);
        case (off)
            6'h00:   inst_kind = RK_RX_DHI;
            6'h04:   inst_kind = RK_RX_DLO;
            6'h0C:   inst_kind = RK_RX_XA;
            6'h10:   inst_kind = RK_RX_XB;
            6'h14:   inst_kind = RK_RX_EN;
            6'h30:   inst_kind = RK_RX_ROW;
            6'h18:   inst_kind = RK_TX_DHI;
            6'h1C:   inst_kind = RK_TX_DLO;
            6'h24:   inst_kind = RK_TX_XA;
            6'h2C:   inst_kind = RK_TX_XB;
            6'h34:   inst_kind = first ? RK_ADDR_CTL : RK_NONE;
            default: inst_kind = RK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dma_rf_decode.sv
// Address decoder: turns a byte address into a register kind and an
// instance index. Assumes ADDR_W covers the global interrupt registers.
module dma_rf_decode
    import dma_rf_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int NUM_INST = 2,
    parameter int IW       = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IW-1:0]     inst
);
    localparam logic [ADDR_W-1:0] REGION_END = ADDR_W'(NUM_INST * INST_SPAN);

    // Combinational decode; misaligned addresses decode to nothing.
    always_comb begin
        kind = RK_NONE;
        inst = addr[6 +: IW];
        if (addr[1:0] == 2'b00) begin
            if (addr < REGION_END)
                kind = inst_kind(addr[5:0], inst == '0);
            else if (addr == ADDR_W'(STATUS_ADDR))
                kind = RK_STATUS;
            else if (addr == ADDR_W'(PEND_ADDR))
                kind = RK_PEND;
            else if (addr == ADDR_W'(MASK_ADDR))
                kind = RK_MASK;
        end
    end
endmodule

// File: rtl/dma_rf_inst.sv
// Register set of one receive/transmit channel pair. Assumes the caller
// gates writes with sel for this instance. Emits one-cycle start strobes.
module dma_rf_inst
    import dma_rf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        sel,
    input  reg_kind_e   kind,
    input  logic [31:0] wdata,
    output logic [31:0] rx_dhi,
    output logic [31:0] rx_dlo,
    output logic        rx_en,
    output logic [31:0] rx_row,
    output logic [31:0] tx_dhi,
    output logic [31:0] tx_dlo,
    output logic        start_rx,
    output logic        start_tx,
    output logic [31:0] rd_word
);
    logic [31:0] rx_xa, rx_xb, tx_xa, tx_xb;

    // Register writes and start strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_dhi <= '0; rx_dlo <= '0; rx_xa <= '0; rx_xb <= '0;
            rx_en <= 1'b0; rx_row <= '0;
            tx_dhi <= '0; tx_dlo <= '0; tx_xa <= '0; tx_xb <= '0;
            start_rx <= 1'b0; start_tx <= 1'b0;
        end else begin
            start_rx <= 1'b0;
            start_tx <= 1'b0;
            if (wr_en && sel) begin
                case (kind)
                    RK_RX_DHI: rx_dhi <= wdata;
                    RK_RX_DLO: rx_dlo <= wdata;
                    RK_RX_XA:  rx_xa  <= wdata;
                    RK_RX_XB:  rx_xb  <= wdata;
                    RK_RX_EN: begin
                        rx_en    <= wdata[0];
                        start_rx <= wdata[0] & ~rx_en;
                    end
                    RK_RX_ROW: rx_row <= wdata;
                    RK_TX_DHI: tx_dhi <= wdata;
                    RK_TX_DLO: begin
                        tx_dlo   <= wdata;
                        start_tx <= 1'b1;
                    end
                    RK_TX_XA:  tx_xa  <= wdata;
                    RK_TX_XB:  tx_xb  <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // Read-back word for the selected register kind.
    always_comb begin
        case (kind)
            RK_RX_DHI: rd_word = rx_dhi;
            RK_RX_DLO: rd_word = rx_dlo;
            RK_RX_XA:  rd_word = rx_xa;
            RK_RX_XB:  rd_word = rx_xb;
            RK_RX_EN:  rd_word = {31'b0, rx_en};
            RK_RX_ROW: rd_word = rx_row;
            RK_TX_DHI: rd_word = tx_dhi;
            RK_TX_DLO: rd_word = tx_dlo;
            RK_TX_XA:  rd_word = tx_xa;
            RK_TX_XB:  rd_word = tx_xb;
            default:   rd_word = '0;
        endcase
    end

    AST_TX_START_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        start_tx |-> $past(wr_en && sel && kind == RK_TX_DLO)); // R10
    AST_RX_START_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        start_rx |-> (rx_en && !$past(rx_en))); // R11
endmodule

// File: rtl/dma_rf_irq.sv
// Sticky per-channel completion status, write-1-clear, with a mask and one
// interrupt line. A set pulse wins over a clear in the same cycle.
module dma_rf_irq #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] done,
    input  logic           wr_status,
    input  logic           wr_mask,
    input  logic [NCH-1:0] wdata,
    output logic [NCH-1:0] status,
    output logic [NCH-1:0] mask,
    output logic [NCH-1:0] pend,
    output logic           irq
);
    logic [NCH-1:0] clr;

    // Clear vector from a status write.
    always_comb clr = wr_status ? wdata : '0;

    // Status and mask register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= '0;
        end else begin
            status <= (status & ~clr) | done;
            if (wr_mask) mask <= wdata;
        end
    end

    // Pending view and interrupt line.
    always_comb begin
        pend = status & mask;
        irq  = |pend;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (done != '0) |=> ((status & $past(done)) == $past(done))); // R7
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && done == '0) |=> ((status & $past(wdata)) == '0)); // R6
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_status && done == '0) |=> $stable(status)); // R5
endmodule

// File: rtl/dma_regfile.sv
// Top of the DMA register and interrupt unit. Decodes the register port,
// holds per-pair channel registers, the addressing-control bit and the
// interrupt registers. Assumes NCH = 2*NUM_INST <= 32.
module dma_regfile
    import dma_rf_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int NUM_INST = 2,
    localparam int NCH     = 2 * NUM_INST
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NCH-1:0]        chain_done,
    output logic                  irq,
    output logic                  addr32_mode,
    output logic [NCH*32-1:0]     chan_desc_hi,
    output logic [NCH*32-1:0]     chan_desc_lo,
    output logic [NUM_INST-1:0]   rx_enable,
    output logic [NUM_INST*32-1:0] rx_row_bytes,
    output logic [NCH-1:0]        chan_start
);
    localparam int IW = (NUM_INST > 1) ? $clog2(NUM_INST) : 1;

    reg_kind_e     kind;
    logic [IW-1:0] inst;
    logic [31:0]   inst_rd [NUM_INST];
    logic [NCH-1:0] status, mask, pend;
    logic [31:0]   rd_next;

    dma_rf_decode #(.ADDR_W(ADDR_W), .NUM_INST(NUM_INST), .IW(IW)) u_dec (
        .addr(bus_addr), .kind(kind), .inst(inst)
    );

    for (genvar i = 0; i < NUM_INST; i++) begin : g_inst
        dma_rf_inst u_inst (
            .clk(clk), .rst_n(rst_n), .wr_en(bus_wr),
            .sel(inst == IW'(i)), .kind(kind), .wdata(bus_wdata),
            .rx_dhi(chan_desc_hi[(2*i)*32 +: 32]),
            .rx_dlo(chan_desc_lo[(2*i)*32 +: 32]),
            .rx_en(rx_enable[i]),
            .rx_row(rx_row_bytes[i*32 +: 32]),
            .tx_dhi(chan_desc_hi[(2*i+1)*32 +: 32]),
            .tx_dlo(chan_desc_lo[(2*i+1)*32 +: 32]),
            .start_rx(chan_start[2*i]),
            .start_tx(chan_start[2*i+1]),
            .rd_word(inst_rd[i])
        );
    end

    dma_rf_irq #(.NCH(NCH)) u_irq (
        .clk(clk), .rst_n(rst_n), .done(chain_done),
        .wr_status(bus_wr && kind == RK_STATUS),
        .wr_mask(bus_wr && kind == RK_MASK),
        .wdata(bus_wdata[NCH-1:0]),
        .status(status), .mask(mask), .pend(pend), .irq(irq)
    );

    // Addressing-control bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                           addr32_mode <= 1'b0;
        else if (bus_wr && kind == RK_ADDR_CTL) addr32_mode <= bus_wdata[0];
    end

    // Read data selection.
    always_comb begin
        case (kind)
            RK_NONE:     rd_next = '0;
            RK_ADDR_CTL: rd_next = {31'b0, addr32_mode};
            RK_STATUS:   rd_next = 32'(status);
            RK_PEND:     rd_next = 32'(pend);
            RK_MASK:     rd_next = 32'(mask);
            default:     rd_next = inst_rd[inst];
        endcase
    end

    // Registered read port, holds between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && kind == RK_NONE) |=> (bus_rdata == '0)); // R12
    AST_CTL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && kind == RK_ADDR_CTL) |=> $stable(addr32_mode)); // R4
endmodule

// File: tb/dma_regfile_test.sv
module dma_regfile_test;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_INST = 2;
    localparam int NCH = 4;
    localparam int NV = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] chain_done = '0;
    logic irq, addr32_mode;
    logic [NCH*32-1:0] chan_desc_hi, chan_desc_lo;
    logic [NUM_INST-1:0] rx_enable;
    logic [NUM_INST*32-1:0] rx_row_bytes;
    logic [NCH-1:0] chan_start;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    dma_regfile #(.ADDR_W(20), .NUM_INST(NUM_INST)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .chain_done(chain_done), .irq(irq), .addr32_mode(addr32_mode),
        .chan_desc_hi(chan_desc_hi), .chan_desc_lo(chan_desc_lo),
        .rx_enable(rx_enable), .rx_row_bytes(rx_row_bytes),
        .chan_start(chan_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vector: {tag(24), write(1), addr(20), data(32), expected read(32)}
    localparam logic [108:0] VEC [NV] = '{
        {"R2 ", 1'b1, 20'h00000, 32'h1111_0000, 32'h0},
        {"R2 ", 1'b1, 20'h00004, 32'h1111_0004, 32'h0},
        {"R2 ", 1'b1, 20'h0000C, 32'h1111_000C, 32'h0},
        {"R2 ", 1'b1, 20'h00010, 32'h1111_0010, 32'h0},
        {"R2 ", 1'b1, 20'h00030, 32'h1111_0030, 32'h0},
        {"R3 ", 1'b1, 20'h00018, 32'h2222_0000, 32'h0},
        {"R3 ", 1'b1, 20'h0001C, 32'h2222_0004, 32'h0},
        {"R3 ", 1'b1, 20'h00024, 32'h2222_000C, 32'h0},
        {"R3 ", 1'b1, 20'h0002C, 32'h2222_0014, 32'h0},
        {"R1 ", 1'b1, 20'h00040, 32'h3333_0000, 32'h0},
        {"R1 ", 1'b1, 20'h0005C, 32'h4444_0004, 32'h0},
        {"R4 ", 1'b1, 20'h00034, 32'hFFFF_FFFF, 32'h0},
        {"R12", 1'b1, 20'h00074, 32'h0000_0005, 32'h0},
        {"R12", 1'b1, 20'h00008, 32'hDEAD_BEEF, 32'h0},
        {"R8 ", 1'b1, 20'h80004, 32'h0000_000F, 32'h0},
        {"R2 ", 1'b0, 20'h00000, 32'h0, 32'h1111_0000},
        {"R2 ", 1'b0, 20'h00004, 32'h0, 32'h1111_0004},
        {"R2 ", 1'b0, 20'h0000C, 32'h0, 32'h1111_000C},
        {"R2 ", 1'b0, 20'h00010, 32'h0, 32'h1111_0010},
        {"R2 ", 1'b0, 20'h00030, 32'h0, 32'h1111_0030},
        {"R3 ", 1'b0, 20'h00018, 32'h0, 32'h2222_0000},
        {"R3 ", 1'b0, 20'h00024, 32'h0, 32'h2222_000C},
        {"R3 ", 1'b0, 20'h0002C, 32'h0, 32'h2222_0014},
        {"R1 ", 1'b0, 20'h0005C, 32'h0, 32'h4444_0004},
        {"R4 ", 1'b0, 20'h00034, 32'h0, 32'h0000_0001},
        {"R12", 1'b0, 20'h00074, 32'h0, 32'h0},
        {"R12", 1'b0, 20'h00008, 32'h0, 32'h0},
        {"R12", 1'b0, 20'h00100, 32'h0, 32'h0},
        {"R12", 1'b0, 20'h00002, 32'h0, 32'h0},
        {"R8 ", 1'b0, 20'h80004, 32'h0, 32'h0}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [19:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                failures++;
                $display("FAIL watchdog: got %0d expected below 20000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // R13 reset state
        check("R13 irq", {31'b0, irq}, 32'h0);
        check("R13 rdata", bus_rdata, 32'h0);
        check("R13 start", {28'b0, chan_start}, 32'h0);
        check("R13 addr32", {31'b0, addr32_mode}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][84]) begin
                wr(VEC[i][83:64], VEC[i][63:32]);
            end else begin
                rd(VEC[i][83:64], r);
                check($sformatf("%s vector %0d", VEC[i][108:85], i), r, VEC[i][31:0]);
            end
        end

        // R1 channel slices on the ports
        check("R1 ch1 desc lo", chan_desc_lo[1*32 +: 32], 32'h2222_0004);
        check("R1 ch2 desc hi", chan_desc_hi[2*32 +: 32], 32'h3333_0000);
        check("R1 ch3 desc lo", chan_desc_lo[3*32 +: 32], 32'h4444_0004);
        check("R1 row inst0", rx_row_bytes[31:0], 32'h1111_0030);
        check("R4 addr32 port", {31'b0, addr32_mode}, 32'h1);

        // R10 transmit start strobe
        wr(20'h0005C, 32'h5555_0000);
        check("R10 start ch3", {28'b0, chan_start}, 32'h8);
        @(negedge clk);
        check("R10 strobe ends", {28'b0, chan_start}, 32'h0);

        // R11 receive enable rising
        wr(20'h00054, 32'h1);
        check("R11 start ch2", {28'b0, chan_start}, 32'h4);
        check("R11 rx_enable", {30'b0, rx_enable}, 32'h2);
        wr(20'h00054, 32'h1);
        check("R11 no restart", {28'b0, chan_start}, 32'h0);
        wr(20'h00014, 32'hFFFF_FFFF);
        rd(20'h00014, r);
        check("R2 enable bit only", r, 32'h1);

        // R5 status set, R9 masked
        @(negedge clk); chain_done = 4'b0101;
        @(negedge clk); chain_done = 4'b0000;
        check("R9 irq masked", {31'b0, irq}, 32'h0);
        rd(20'h80000, r);
        check("R5 status", r, 32'h5);

        // R8 pending = status & mask, R9 irq
        wr(20'h80008, 32'h4);
        check("R9 irq on", {31'b0, irq}, 32'h1);
        rd(20'h80004, r);
        check("R8 pending", r, 32'h4);
        rd(20'h80008, r);
        check("R8 mask", r, 32'h4);

        // R6 write-1-clear
        wr(20'h80000, 32'h4);
        check("R9 irq off", {31'b0, irq}, 32'h0);
        rd(20'h80000, r);
        check("R6 partial clear", r, 32'h1);

        // R7 set wins over clear
        @(negedge clk);
        chain_done = 4'b0010; bus_wr = 1'b1; bus_addr = 20'h80000; bus_wdata = 32'h2;
        @(negedge clk);
        chain_done = 4'b0000; bus_wr = 1'b0;
        rd(20'h80000, r);
        check("R7 set wins", r, 32'h3);

        // R6 clear all
        wr(20'h80000, 32'hFFFF_FFFF);
        rd(20'h80000, r);
        check("R6 clear all", r, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule